// File: doc/BRIEF.md
# Host Bus Cycle Status and Control Registers

This block sits between an embedded CPU and the engines that run cycles on a host bus. The CPU raises a one-cycle request strobe to start a configuration, I/O or DMA cycle. The block passes a request on as a start pulse only when no cycle of the same class is running. Configuration and I/O requests form one class. DMA requests form a second class. A request that arrives while its class is busy is dropped, and a sticky error bit records that it was dropped.

The block latches the completion events from the engines and the abort events from the bus side into sticky status bits. Software clears each of these bits by writing 1 to it. Each abort flag is also recorded in a separate copy that feeds a configuration-space status register. That copy has its own clear input. A control register holds a byte-swap bit, a burst-off bit and six interrupt enables. The enabled pending events are ORed into a level interrupt to the CPU.

Register reads are combinational from the address. Writes take effect on the clock edge.

Top module: `hbs_regs`

## Requirements
- R1: After a synchronous reset, the status register, the control register and the abort copy all read 0, and `cpu_irq` is low.
- R2: A class is busy while its engine busy input is high, and in the cycle after the block issued a start pulse for that class. A configuration or I/O request in a cycle where the config/I/O class is busy produces no start pulse, and status bit 8 is set on the next edge.
- R3: A DMA request in a cycle where the DMA class is busy produces no `dma_go`, and status bit 9 is set on the next edge.
- R4: A request while its class is idle produces its start pulse in the same cycle. At most one start pulse per class is issued in any cycle.
- R5: If configuration and I/O requests arrive in the same idle cycle, the configuration request is started. The I/O request is rejected and sets status bit 8.
- R6: The status register is at offset 0x004. Its bits are: 0 = configuration done, 1 = I/O done, 2 = DMA done, 3 = external write to local memory done, 4 = received target abort, 5 = received master abort, 6 = target timer expired, 8 = duplicate configuration/I/O request, 9 = duplicate DMA request. All other bits read 0. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When a hardware set and a software clear reach the same status bit (or abort-copy bit) in one cycle, the bit ends up set.
- R8: A target abort or master abort pulse sets status bit 4 or 5 on the same edge as bit 0 or 1 of `cs_abort`. Clearing either copy leaves the other copy unchanged. `cs_abort` is cleared by `cs_clr` bits written as 1.
- R9: The control register is at offset 0x008. Bits 7:0 are read/write and all other bits read 0. Bit 0 drives `ctl_swap` and bit 1 drives `ctl_burst_off`. Any other offset reads 0 and ignores writes.
- R10: `cpu_irq` is high exactly when a pending status bit is paired with a set enable bit. The pairs (enable bit → status bit) are: 2→0, 3→1, 4→2, 5→3, 6→8, 7→9. The interrupt stays high until software clears the pending bit or the enable bit.
- R11: Each done input pulse sets its pending status bit on the next edge. The bit holds until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| req_cfg | input | 1 | Configuration cycle request strobe |
| req_io | input | 1 | I/O cycle request strobe |
| req_dma | input | 1 | DMA cycle request strobe |
| cfgio_busy | input | 1 | Config/I/O engine running |
| dma_busy | input | 1 | DMA engine running |
| cfg_go | output | 1 | Start configuration cycle |
| io_go | output | 1 | Start I/O cycle |
| dma_go | output | 1 | Start DMA cycle |
| cfg_done | input | 1 | Configuration cycle completed |
| io_done | input | 1 | I/O cycle completed |
| dma_done | input | 1 | DMA cycle completed |
| memwr_done | input | 1 | External write to local memory completed |
| tgt_abort | input | 1 | Received target abort pulse |
| mst_abort | input | 1 | Received master abort pulse |
| tgt_timeout | input | 1 | Target retry timer expired pulse |
| cs_clr | input | 2 | Clear strobes for abort copy (bit0 target, bit1 master) |
| cs_abort | output | 2 | Abort copy for configuration-space status |
| ctl_swap | output | 1 | Byte swap enable |
| ctl_burst_off | output | 1 | Burst writes disabled |
| cpu_irq | output | 1 | Level interrupt to the CPU |

## Verification
The bench targets five corner cases.

A request made one cycle after its own class was started must be rejected. A design that looks only at the engine busy input would start a second cycle there.

Configuration and I/O requests in the same idle cycle must start only the configuration cycle and flag a duplicate. A wrong design would either issue two start pulses or lose the error.

A write-1 clear that lands in the same cycle as a new event must leave the bit set. Otherwise the event would be silently lost.

Clears of the abort copy and of the status flags must stay independent. A shared flop would show up as a flag cleared from the wrong side.

A wrong pairing of interrupt-enable bits to status bits would show up as `cpu_irq` rising for a masked event.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    localparam int ST_W        = 10;
    localparam int CTL_W       = 8;
    localparam int B_CFG_DONE  = 0;
    localparam int B_IO_DONE   = 1;
    localparam int B_DMA_DONE  = 2;
    localparam int B_MWR_DONE  = 3;
    localparam int B_RTA       = 4;
    localparam int B_RMA       = 5;
    localparam int B_TTE       = 6;
    localparam int B_DUP_CI    = 8;
    localparam int B_DUP_DMA   = 9;
    localparam logic [ST_W-1:0] ST_MASK = 10'h37F;
    localparam logic [11:0] OFF_STATUS = 12'h004;
    localparam logic [11:0] OFF_CTL    = 12'h008;

    typedef struct packed {
        logic burst_off;
        logic swap;
    } ctl_mode_t;

    typedef struct packed {
        logic [5:0] ien;
        ctl_mode_t  mode;
    } ctl_reg_t;

    // Status bits that each interrupt-enable bit (2..7) guards, in enable order
    function automatic logic [5:0] irq_events(input logic [ST_W-1:0] st);
        return {st[B_DUP_DMA], st[B_DUP_CI], st[B_MWR_DONE],
                st[B_DMA_DONE], st[B_IO_DONE], st[B_CFG_DONE]};
    endfunction
endpackage

// File: rtl/hbs_req_gate.sv
module hbs_req_gate #(
    parameter int N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    input  logic             busy,
    output logic [N_REQ-1:0] go,
    output logic             dup
);
    logic             go_q;
    logic             class_busy;
    logic [N_REQ-1:0] first;

    assign class_busy = busy | go_q;
    assign first      = req & (~req + {{(N_REQ-1){1'b0}}, 1'b1});
    assign go         = class_busy ? '0 : first;
    assign dup        = ((|req) & class_busy) | (|(req & ~first));

    always_ff @(posedge clk) begin
        if (rst) go_q <= 1'b0;
        else     go_q <= |go;
    end

    // R4: never more than one start pulse per class
    a_r4_one_go: assert property (@(posedge clk) disable iff (rst) $onehot0(go));
    // R2: engine busy blocks every start in this class
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |-> go == '0);
    // R2: a start is never followed directly by another start
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (|go) |=> go == '0);
endmodule

// File: rtl/hbs_w1c.sv
module hbs_w1c #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    // R7: a hardware set always survives a simultaneous clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> (q & $past(set)) == $past(set));
    // R6: a bit with neither set nor clear keeps its value
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (set == '0 && clr == '0) |=> $stable(q));
endmodule

// File: rtl/hbs_regs.sv
module hbs_regs
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_cfg,
    input  logic              req_io,
    input  logic              req_dma,
    input  logic              cfgio_busy,
    input  logic              dma_busy,
    output logic              cfg_go,
    output logic              io_go,
    output logic              dma_go,
    input  logic              cfg_done,
    input  logic              io_done,
    input  logic              dma_done,
    input  logic              memwr_done,
    input  logic              tgt_abort,
    input  logic              mst_abort,
    input  logic              tgt_timeout,
    input  logic [1:0]        cs_clr,
    output logic [1:0]        cs_abort,
    output logic              ctl_swap,
    output logic              ctl_burst_off,
    output logic              cpu_irq
);
    localparam int PAD_ST  = DATA_W - ST_W;
    localparam int PAD_CTL = DATA_W - CTL_W;

    logic [1:0]      ci_go;
    logic [0:0]      d_go;
    logic            dup_ci, dup_dma;
    logic [ST_W-1:0] st_set, st_clr, st_q;
    logic            wr_st, wr_ctl;
    ctl_reg_t        ctl_q;

    hbs_req_gate #(.N_REQ(2)) u_gate_ci (
        .clk(clk), .rst(rst), .req({req_io, req_cfg}), .busy(cfgio_busy),
        .go(ci_go), .dup(dup_ci));

    hbs_req_gate #(.N_REQ(1)) u_gate_dma (
        .clk(clk), .rst(rst), .req(req_dma), .busy(dma_busy),
        .go(d_go), .dup(dup_dma));

    assign cfg_go = ci_go[0];
    assign io_go  = ci_go[1];
    assign dma_go = d_go[0];

    assign wr_st  = reg_wr && (reg_addr == OFF_STATUS[ADDR_W-1:0]);
    assign wr_ctl = reg_wr && (reg_addr == OFF_CTL[ADDR_W-1:0]);

    always_comb begin
        st_set             = '0;
        st_set[B_CFG_DONE] = cfg_done;
        st_set[B_IO_DONE]  = io_done;
        st_set[B_DMA_DONE] = dma_done;
        st_set[B_MWR_DONE] = memwr_done;
        st_set[B_RTA]      = tgt_abort;
        st_set[B_RMA]      = mst_abort;
        st_set[B_TTE]      = tgt_timeout;
        st_set[B_DUP_CI]   = dup_ci;
        st_set[B_DUP_DMA]  = dup_dma;
        st_clr             = wr_st ? (reg_wdata[ST_W-1:0] & ST_MASK) : '0;
    end

    hbs_w1c #(.W(ST_W)) u_status (
        .clk(clk), .rst(rst), .set(st_set), .clr(st_clr), .q(st_q));

    hbs_w1c #(.W(2)) u_cs_copy (
        .clk(clk), .rst(rst), .set({mst_abort, tgt_abort}), .clr(cs_clr),
        .q(cs_abort));

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (wr_ctl) ctl_q <= ctl_reg_t'(reg_wdata[CTL_W-1:0]);
    end

    assign ctl_swap      = ctl_q.mode.swap;
    assign ctl_burst_off = ctl_q.mode.burst_off;
    assign cpu_irq       = |(irq_events(st_q) & ctl_q.ien);

    always_comb begin
        if (reg_addr == OFF_STATUS[ADDR_W-1:0])
            reg_rdata = {{PAD_ST{1'b0}}, st_q};
        else if (reg_addr == OFF_CTL[ADDR_W-1:0])
            reg_rdata = {{PAD_CTL{1'b0}}, ctl_q};
        else
            reg_rdata = '0;
    end

    // R2: a config/I/O request against a busy engine is flagged next edge
    a_r2_dup_flag: assert property (@(posedge clk) disable iff (rst)
        ((req_cfg || req_io) && cfgio_busy) |=> st_q[B_DUP_CI]);
    // R3: a DMA request against a busy engine is dropped and flagged
    a_r3_dma_reject: assert property (@(posedge clk) disable iff (rst)
        (req_dma && dma_busy) |-> !dma_go);
    a_r3_dma_flag: assert property (@(posedge clk) disable iff (rst)
        (req_dma && dma_busy) |=> st_q[B_DUP_DMA]);
    // R5: simultaneous config and I/O never start the I/O cycle
    a_r5_cfg_first: assert property (@(posedge clk) disable iff (rst)
        (req_cfg && req_io) |-> !io_go);
    // R8: both abort copies are set on the same edge
    a_r8_rta_pair: assert property (@(posedge clk) disable iff (rst)
        tgt_abort |=> (st_q[B_RTA] && cs_abort[0]));
    a_r8_rma_pair: assert property (@(posedge clk) disable iff (rst)
        mst_abort |=> (st_q[B_RMA] && cs_abort[1]));
    // R10: with no register write the interrupt cannot drop
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && !reg_wr) |=> cpu_irq);
endmodule

// File: tb/hbs_regs_tb.sv
module hbs_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        req_cfg, req_io, req_dma, cfgio_busy, dma_busy;
    logic        cfg_go, io_go, dma_go;
    logic        cfg_done, io_done, dma_done, memwr_done;
    logic        tgt_abort, mst_abort, tgt_timeout;
    logic [1:0]  cs_clr, cs_abort;
    logic        ctl_swap, ctl_burst_off, cpu_irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done_run = 0;

    // reference state
    logic [9:0] m_st;
    logic [7:0] m_ctl;
    logic [1:0] m_cs;
    logic       m_goq_ci, m_goq_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbs_regs dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_cfg(req_cfg), .req_io(req_io), .req_dma(req_dma),
        .cfgio_busy(cfgio_busy), .dma_busy(dma_busy),
        .cfg_go(cfg_go), .io_go(io_go), .dma_go(dma_go),
        .cfg_done(cfg_done), .io_done(io_done), .dma_done(dma_done),
        .memwr_done(memwr_done), .tgt_abort(tgt_abort), .mst_abort(mst_abort),
        .tgt_timeout(tgt_timeout), .cs_clr(cs_clr), .cs_abort(cs_abort),
        .ctl_swap(ctl_swap), .ctl_burst_off(ctl_burst_off), .cpu_irq(cpu_irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_go();
        logic ci_b, d_b;
        ci_b = cfgio_busy | m_goq_ci;
        d_b  = dma_busy | m_goq_d;
        return {req_dma & ~d_b, req_io & ~req_cfg & ~ci_b, req_cfg & ~ci_b};
    endfunction

    function automatic logic exp_irq();
        logic [5:0] ev;
        ev = {m_st[9], m_st[8], m_st[3], m_st[2], m_st[1], m_st[0]};
        return |(ev & m_ctl[7:2]);
    endfunction

    function automatic logic [31:0] exp_rd();
        if (reg_addr == 12'h004) return {22'd0, m_st};
        if (reg_addr == 12'h008) return {24'd0, m_ctl};
        return 32'd0;
    endfunction

    task automatic idle_inputs();
        reg_addr = 12'h004; reg_wr = 0; reg_wdata = 0;
        req_cfg = 0; req_io = 0; req_dma = 0; cfgio_busy = 0; dma_busy = 0;
        cfg_done = 0; io_done = 0; dma_done = 0; memwr_done = 0;
        tgt_abort = 0; mst_abort = 0; tgt_timeout = 0; cs_clr = 0;
    endtask

    // inputs are already driven (after a negedge); check, then advance one edge
    task automatic step();
        logic [2:0] g;
        logic       dci, dd;
        logic [9:0] set, clr;
        #1;
        g = exp_go();
        check("R2 R3 R4 R5 go pulses", {29'd0, dma_go, io_go, cfg_go}, {29'd0, g});
        check("R6 R9 R11 read data", reg_rdata, exp_rd());
        check("R10 irq", {31'd0, cpu_irq}, {31'd0, exp_irq()});
        check("R8 abort copy", {30'd0, cs_abort}, {30'd0, m_cs});
        check("R9 ctl outputs", {30'd0, ctl_burst_off, ctl_swap}, {30'd0, m_ctl[1:0]});
        dci = ((req_cfg | req_io) & (cfgio_busy | m_goq_ci)) | (req_cfg & req_io);
        dd  = req_dma & (dma_busy | m_goq_d);
        set = {dd, dci, 1'b0, tgt_timeout, mst_abort, tgt_abort,
               memwr_done, dma_done, io_done, cfg_done};
        clr = (reg_wr && reg_addr == 12'h004) ? (reg_wdata[9:0] & 10'h37F) : 10'd0;
        @(posedge clk);
        m_st     = (m_st & ~clr) | set;
        m_cs     = (m_cs & ~cs_clr) | {mst_abort, tgt_abort};
        if (reg_wr && reg_addr == 12'h008) m_ctl = reg_wdata[7:0];
        m_goq_ci = g[0] | g[1];
        m_goq_d  = g[2];
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        idle_inputs();
        rst = 1;
        m_st = 0; m_ctl = 0; m_cs = 0; m_goq_ci = 0; m_goq_d = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset values
        check("R1 status", reg_rdata, 32'd0);
        reg_addr = 12'h008; #1;
        check("R1 control", reg_rdata, 32'd0);
        check("R1 irq/copy", {29'd0, cpu_irq, cs_abort}, 32'd0);

        // R4 then R2: back-to-back config requests, second rejected via own start
        idle_inputs(); req_cfg = 1; step();
        step();
        idle_inputs(); step();
        check("R2 dup bit after back-to-back", reg_rdata & 32'h100, 32'h100);
        // R5: simultaneous cfg and io while idle
        idle_inputs(); reg_wr = 1; reg_wdata = 32'h100; step();
        idle_inputs(); req_cfg = 1; req_io = 1; step();
        idle_inputs(); step();
        check("R5 dup bit after simultaneous", reg_rdata & 32'h100, 32'h100);
        // R3: DMA request against busy engine
        idle_inputs(); req_dma = 1; dma_busy = 1; step();
        idle_inputs(); step();
        check("R3 dup dma bit", reg_rdata & 32'h200, 32'h200);
        // R7: set and clear in the same cycle
        idle_inputs(); tgt_abort = 1; cs_clr = 2'b01; reg_wr = 1; reg_wdata = 32'h3FF; step();
        idle_inputs(); step();
        check("R7 set beats clear", reg_rdata & 32'h010, 32'h010);
        // R8: clear copy only, status flag stays
        idle_inputs(); cs_clr = 2'b01; step();
        idle_inputs(); step();
        check("R8 status flag kept after copy clear", reg_rdata & 32'h010, 32'h010);
        // R10: enable DMA-done interrupt, pend, then clear
        idle_inputs(); reg_addr = 12'h008; reg_wr = 1; reg_wdata = 32'hFFFF_FF10; step();
        idle_inputs(); dma_done = 1; step();
        idle_inputs(); step();
        check("R10 irq raised", {31'd0, cpu_irq}, 32'd1);

        for (int i = 0; i < N_RAND; i++) begin
            logic [3:0] a;
            idle_inputs();
            a = 4'($urandom_range(0, 9));
            reg_addr   = (a < 4) ? 12'h004 : (a < 7) ? 12'h008 : 12'($urandom);
            reg_wr     = ($urandom_range(0, 5) == 0);
            reg_wdata  = $urandom;
            req_cfg    = ($urandom_range(0, 3) == 0);
            req_io     = ($urandom_range(0, 3) == 0);
            req_dma    = ($urandom_range(0, 3) == 0);
            cfgio_busy = ($urandom_range(0, 2) == 0);
            dma_busy   = ($urandom_range(0, 2) == 0);
            cfg_done   = ($urandom_range(0, 7) == 0);
            io_done    = ($urandom_range(0, 7) == 0);
            dma_done   = ($urandom_range(0, 7) == 0);
            memwr_done = ($urandom_range(0, 7) == 0);
            tgt_abort  = ($urandom_range(0, 9) == 0);
            mst_abort  = ($urandom_range(0, 9) == 0);
            tgt_timeout= ($urandom_range(0, 9) == 0);
            cs_clr     = 2'($urandom);
            step();
        end
        done_run = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule